// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block sits behind the active-low hardware reset pin of a parallel NOR-style flash interface. It passes the pin through a synchronizer and measures how long it stays low. Only a pulse that lasts at least `T_RP` clock cycles counts as a reset. An accepted reset does four things: it issues an abort to the embedded program/erase engine, runs an internal reset interval, clears the command state machine back to array-read mode, and then holds reads off for a recovery interval after the pin is released.

The internal reset takes a different time depending on whether an embedded operation was running when the reset was accepted. If one was running, the interval is `T_READY_EMB` cycles and ready/busy reads busy for all of it. If none was running, the interval is the shorter `T_READY_IDLE` and ready/busy stays ready. Whenever the synchronized pin is low, and until recovery has ended, the data outputs are held in high impedance and command cycles are ignored. The interrupted operation is not restarted.

Top module: `flash_rst_seq`

## Requirements
- R1: The pin passes through a two-stage synchronizer. A reset is accepted only after `T_RP` consecutive synchronized low samples. A shorter low pulse produces no `abort_o`, no `fsm_clr_o` and no change of `ready_o`.
- R2: From the clock edge after the first synchronized low sample, `out_hiz_o` and `cmd_block_o` are 1. They stay 1 while the pin is low, through the internal reset and through recovery. They are 0 in the idle state.
- R3: `abort_o` is a pulse one cycle wide. It is high in the cycle after the edge that takes the `T_RP`-th synchronized low sample, which is `T_RP`+2 edges after the pin first falls.
- R4: `fsm_clr_o` is a pulse one cycle wide. It is high in the cycle after the internal reset interval ends.
- R5: If `emb_busy_i` was 1 at acceptance, the internal reset lasts `T_READY_EMB` cycles, starting with the abort cycle. `ready_o` is 0 for exactly those cycles and then returns to 1.
- R6: If `emb_busy_i` was 0 at acceptance, the internal reset lasts `T_READY_IDLE` cycles and `ready_o` stays 1 throughout.
- R7: Recovery starts at whichever comes later: the first synchronized high sample, or the end of the internal reset. After `T_RH` cycles of recovery, `out_hiz_o` and `cmd_block_o` return to 0.
- R8: After `rst_ni`, the block is idle, `abort_o`, `fsm_clr_o`, `out_hiz_o` and `cmd_block_o` are 0, and `ready_o` is the inverse of `emb_busy_i`.
- R9: Outside an accepted reset (idle, or still qualifying a low pulse), `ready_o` equals the inverse of `emb_busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pin_rst_ni | input | 1 | Asynchronous active-low hardware reset pin |
| emb_busy_i | input | 1 | Embedded program/erase is running |
| abort_o | output | 1 | One-cycle abort to the algorithm engine |
| out_hiz_o | output | 1 | Force the data outputs to high impedance |
| cmd_block_o | output | 1 | Ignore read and write command cycles |
| ready_o | output | 1 | Ready/busy, 1 = ready |
| fsm_clr_o | output | 1 | One-cycle return of the command state machine to array read |

## Verification
The bench drives a pulse one cycle short of `T_RP`. A width check that is off by one would answer it with an abort or a busy flag. It drives a pulse of exactly `T_RP`, released at acceptance, which finds a design that waits for release before starting the internal reset or that starts recovery too early. It drives an embedded-case reset held long past the internal reset. There, the busy count and the `fsm_clr_o` timing separate the two interval lengths, and a design that picks the wrong interval, or keeps ready/busy busy in the idle case, shows a count or pulse time that does not match. The end of recovery is timed to the cycle in both cases, so a recovery that is one cycle short or long is caught.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RST_LOW = 2'd1,
    ST_INT_RST = 2'd2,
    ST_RECOVER = 2'd3
  } rst_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/flash_rst_timer.sv
module flash_rst_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != {W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R7: interval timer saturates, never wraps into a false match
  a_r7_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}}));

endmodule

// File: rtl/flash_rst_fsm.sv
module flash_rst_fsm
  import flash_rst_pkg::*;
#(
  parameter int unsigned T_RP         = 13,
  parameter int unsigned T_READY_EMB  = 5000,
  parameter int unsigned T_READY_IDLE = 125,
  parameter int unsigned T_RH         = 13,
  parameter int unsigned CNT_W        = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             low_i,
  input  logic             emb_busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             abort_o,
  output logic             out_hiz_o,
  output logic             cmd_block_o,
  output logic             ready_o,
  output logic             fsm_clr_o
);

  // first low sample is taken on entry, so the counter trails the sample count by 2
  localparam logic [CNT_W-1:0] RP_LAST   = CNT_W'((T_RP >= 2) ? T_RP - 2 : 0);
  localparam logic [CNT_W-1:0] EMB_LAST  = CNT_W'((T_READY_EMB  >= 1) ? T_READY_EMB  - 1 : 0);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'((T_READY_IDLE >= 1) ? T_READY_IDLE - 1 : 0);
  localparam logic [CNT_W-1:0] RH_LAST   = CNT_W'((T_RH >= 1) ? T_RH - 1 : 0);
  localparam bit               RP_SHORT  = (T_RP <= 1);

  rst_state_e st_q, st_d;
  logic       qual_q, qual_d;
  logic       emb_q, emb_d;
  logic       abort_q, clr_q;
  logic       accept, done;

  // start qualifying a fresh low pulse (from idle or recovery)
  function automatic void start_low(output rst_state_e s, output logic q, output logic a);
    if (RP_SHORT) begin
      s = ST_INT_RST;
      q = 1'b0;
      a = 1'b1;
    end else begin
      s = ST_RST_LOW;
      q = 1'b0;
      a = 1'b0;
    end
  endfunction

  always_comb begin
    st_d      = st_q;
    qual_d    = qual_q;
    emb_d     = emb_q;
    accept    = 1'b0;
    done      = 1'b0;
    cnt_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (low_i) begin
          start_low(st_d, qual_d, accept);
          cnt_clr_o = 1'b1;
        end
      end
      ST_RST_LOW: begin
        if (!low_i) begin
          st_d      = qual_q ? ST_RECOVER : ST_IDLE;
          cnt_clr_o = 1'b1;
        end else if (!qual_q && cnt_i == RP_LAST) begin
          accept = 1'b1;
        end
      end
      ST_INT_RST: begin
        if (cnt_i == (emb_q ? EMB_LAST : IDLE_LAST)) begin
          done      = 1'b1;
          cnt_clr_o = 1'b1;
          if (low_i) begin
            st_d   = ST_RST_LOW;
            qual_d = 1'b1;
          end else begin
            st_d = ST_RECOVER;
          end
        end
      end
      ST_RECOVER: begin
        if (low_i) begin
          start_low(st_d, qual_d, accept);
          cnt_clr_o = 1'b1;
        end else if (cnt_i == RH_LAST) begin
          st_d      = ST_IDLE;
          cnt_clr_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (accept) begin
      st_d      = ST_INT_RST;
      qual_d    = 1'b0;
      emb_d     = emb_busy_i;
      cnt_clr_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      qual_q  <= 1'b0;
      emb_q   <= 1'b0;
      abort_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      qual_q  <= qual_d;
      emb_q   <= emb_d;
      abort_q <= accept;
      clr_q   <= done;
    end
  end

  assign abort_o     = abort_q;
  assign fsm_clr_o   = clr_q;
  assign out_hiz_o   = (st_q != ST_IDLE);
  assign cmd_block_o = (st_q != ST_IDLE);

  always_comb begin
    if (st_q == ST_INT_RST)                              ready_o = !emb_q;
    else if (st_q == ST_IDLE || (st_q == ST_RST_LOW && !qual_q)) ready_o = !emb_busy_i;
    else                                                 ready_o = 1'b1;
  end

  // R2: a synchronized low sample always leaves the block out of idle
  a_r2_hiz_follows_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> (out_hiz_o && cmd_block_o));

  // R1: abort only follows a low sample
  a_r1_abort_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(low_i));

  // R3: abort is a single-cycle pulse
  a_r3_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  // R4: state-machine clear is a single-cycle pulse
  a_r4_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_clr_o |=> !fsm_clr_o);

  // R5: busy is released once the internal reset has finished
  a_r5_ready_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_clr_o |-> ready_o);

  // R6: an idle-case reset never reports busy in its first cycle
  a_r6_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !$past(emb_busy_i)) |-> ready_o);

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int unsigned T_RP         = 13,
  parameter int unsigned T_READY_EMB  = 5000,
  parameter int unsigned T_READY_IDLE = 125,
  parameter int unsigned T_RH         = 13,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_rst_ni,
  input  logic emb_busy_i,
  output logic abort_o,
  output logic out_hiz_o,
  output logic cmd_block_o,
  output logic ready_o,
  output logic fsm_clr_o
);

  localparam int unsigned CNT_MAX = max2(max2(T_RP, T_RH), max2(T_READY_EMB, T_READY_IDLE));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             pin_s;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;

  flash_rst_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_rst_ni),
    .q_o    (pin_s)
  );

  flash_rst_timer #(
    .W (CNT_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  flash_rst_fsm #(
    .T_RP         (T_RP),
    .T_READY_EMB  (T_READY_EMB),
    .T_READY_IDLE (T_READY_IDLE),
    .T_RH         (T_RH),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .low_i       (!pin_s),
    .emb_busy_i  (emb_busy_i),
    .cnt_i       (cnt),
    .cnt_clr_o   (cnt_clr),
    .abort_o     (abort_o),
    .out_hiz_o   (out_hiz_o),
    .cmd_block_o (cmd_block_o),
    .ready_o     (ready_o),
    .fsm_clr_o   (fsm_clr_o)
  );

endmodule

// File: tb/flash_rst_seq_bench.sv
`timescale 1ns/1ps
module flash_rst_seq_bench;

  localparam int TRP  = 4;
  localparam int TEMB = 20;
  localparam int TIDL = 6;
  localparam int TRH  = 5;

  logic clk = 1'b0;
  logic rst_ni, pin_rst_ni, emb_busy;
  logic abort_o, out_hiz_o, cmd_block_o, ready_o, fsm_clr_o;

  always #2 clk = ~clk;

  flash_rst_seq #(
    .T_RP (TRP), .T_READY_EMB (TEMB), .T_READY_IDLE (TIDL), .T_RH (TRH), .SYNC_STAGES (2)
  ) u_flash_rst_seq (
    .clk_i (clk), .rst_ni (rst_ni), .pin_rst_ni (pin_rst_ni), .emb_busy_i (emb_busy),
    .abort_o (abort_o), .out_hiz_o (out_hiz_o), .cmd_block_o (cmd_block_o),
    .ready_o (ready_o), .fsm_clr_o (fsm_clr_o)
  );

  typedef struct { int kind; int at; } ev_t; // kind 0 = abort, 1 = clear
  ev_t exp_q[$];
  ev_t cur;
  int  cyc = 0;
  int  n_cmp = 0, n_bad = 0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: every pulse must match the next expected event
  always @(negedge clk) begin
    if (rst_ni === 1'b1 && (abort_o || fsm_clr_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected pulse", int'(fsm_clr_o), -1);
      end else begin
        cur = exp_q.pop_front();
        if (cur.kind == 0) begin
          chk(abort_o && !fsm_clr_o, "R3 abort pulse kind", int'(abort_o), 1);
          chk(cyc == cur.at, "R3 abort pulse cycle", cyc, cur.at);
        end else begin
          chk(fsm_clr_o && !abort_o, "R4 clear pulse kind", int'(fsm_clr_o), 1);
          chk(cyc == cur.at, "R4 clear pulse cycle", cyc, cur.at);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int c0, r0, bz, off_at;
    pin_rst_ni = 1'b1;
    emb_busy   = 1'b0;
    rst_ni     = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(2);

    // R8: reset state
    chk(!abort_o && !fsm_clr_o, "R8 pulses idle", int'(abort_o | fsm_clr_o), 0);
    chk(!out_hiz_o && !cmd_block_o, "R8 outputs enabled", int'(out_hiz_o | cmd_block_o), 0);
    chk(ready_o, "R8 ready", int'(ready_o), 1);

    // R9: ready follows engine outside reset
    emb_busy = 1'b1; tick(1);
    chk(!ready_o, "R9 busy passthrough", int'(ready_o), 0);
    emb_busy = 1'b0; tick(1);
    chk(ready_o, "R9 ready passthrough", int'(ready_o), 1);

    // R1: pulse one cycle too short, engine running
    emb_busy = 1'b1;
    pin_rst_ni = 1'b0; c0 = cyc;
    tick(TRP - 1);
    chk(out_hiz_o, "R2 hiz while low", int'(out_hiz_o), 1);
    chk(cmd_block_o, "R2 commands blocked while low", int'(cmd_block_o), 1);
    chk(!ready_o, "R1 ready unchanged during short pulse", int'(ready_o), 0);
    pin_rst_ni = 1'b1;
    tick(8);
    chk(!out_hiz_o && !cmd_block_o, "R1 short pulse leaves idle", int'(out_hiz_o), 0);
    chk(!ready_o, "R1 engine not aborted", int'(ready_o), 0);

    // R3/R5/R4/R7: embedded-case reset held long
    pin_rst_ni = 1'b0; c0 = cyc;
    exp_q.push_back('{0, c0 + TRP + 2});
    exp_q.push_back('{1, c0 + TRP + 2 + TEMB});
    tick(TRP + 2);
    chk(abort_o, "R3 abort at acceptance", int'(abort_o), 1);
    emb_busy = 1'b0;
    bz = 0;
    for (int i = 0; i < TEMB + 6; i++) begin
      if (!ready_o) bz++;
      tick(1);
    end
    chk(bz == TEMB, "R5 busy cycles", bz, TEMB);
    chk(ready_o, "R5 ready after internal reset", int'(ready_o), 1);
    chk(out_hiz_o && cmd_block_o, "R2 hiz while still held", int'(out_hiz_o), 1);
    pin_rst_ni = 1'b1; r0 = cyc;
    off_at = -1;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (off_at < 0 && !out_hiz_o) off_at = cyc;
    end
    chk(off_at == r0 + 3 + TRH, "R7 recovery after release", off_at, r0 + 3 + TRH);
    chk(!cmd_block_o, "R7 commands accepted after recovery", int'(cmd_block_o), 0);

    // R6/R7: idle-case reset, exactly T_RP wide
    pin_rst_ni = 1'b0; c0 = cyc;
    exp_q.push_back('{0, c0 + TRP + 2});
    exp_q.push_back('{1, c0 + TRP + 2 + TIDL});
    tick(TRP);
    pin_rst_ni = 1'b1;
    bz = 0; off_at = -1;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (!ready_o) bz++;
      if (off_at < 0 && cyc > c0 + TRP + 2 && !out_hiz_o) off_at = cyc;
    end
    chk(bz == 0, "R6 no busy in idle case", bz, 0);
    chk(off_at == c0 + TRP + 2 + TIDL + TRH, "R7 recovery after internal reset",
        off_at, c0 + TRP + 2 + TIDL + TRH);

    tick(5);
    chk(exp_q.size() == 0, "R3 missing pulses", exp_q.size(), 0);
    finish_run();
  end

endmodule